// File: doc/BRIEF.md
# SPI Register Access Slave

This block lets an external host read and write a bank of 16-bit registers over a four-wire serial link. The link runs in SPI mode 0 (clock idles low, data sampled on the rising edge and changed on the falling edge, most significant bit first). The whole block runs on the system clock. The serial clock, chip select and host-out data pass through synchroniser chains, and edges are detected on the synchronised clock.

Each frame starts when chip select goes low. The first byte is a command whose top two bits select the access. A write-type frame carries a 16-bit address word. When the address word's top bit is set, a 16-bit data word follows and is committed to the bank. When that bit is clear, the lower 15 bits become the pending read address. A later fetch frame returns four bytes: two zero bytes, then the word at the pending address. A status fetch returns a fixed identification word in the same slot.

The register bank is attached through a plain port. The bank's read data is expected to follow the address combinationally, and a single-cycle write strobe is driven with its address and data.

Top module: `spi_reg_slave`

## Requirements
- R1: The top two bits of the first byte of a frame select the access: 01 is write or address-set, 10 is fetch, 11 is status, and 00 makes the frame do nothing (no write, zeros on MISO). The low six bits of that byte have no effect.
- R2: In a 01 frame whose address word has bit 15 set, the word that follows is written. After the 40th bit, regWe pulses with regAddr equal to address bits 14:0 and regWdata equal to the data word. Both words are sent high byte first.
- R3: In a 01 frame whose address word has bit 15 clear, bits 14:0 become the pending read address and appear on regAddr. No write occurs.
- R4: A 10 frame returns 32 bits on MISO after the command byte, most significant bit first. The first 16 bits are 0, and the last 16 are the bank word at the pending read address.
- R5: An 11 frame returns 0xA5C3 in the last 16 bits, with 0 in the first 16.
- R6: Raising chip select before a frame completes aborts it. No write is committed, and the next frame is decoded from its first bit.
- R7: regWe is high for exactly one system clock per complete write frame. Serial clocks beyond the 40th bit have no effect.
- R8: MISO is 0 while chip select is high.
- R9: After reset, regWe is 0, regAddr is 0 and MISO is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| spiSclk | input | 1 | Serial clock from host, idle low |
| spiCsN | input | 1 | Active-low frame select from host |
| spiMosi | input | 1 | Serial data from host |
| spiMiso | output | 1 | Serial data to host |
| regAddr | output | 15 | Register bank address (write address during regWe, else pending read address) |
| regWdata | output | 16 | Register bank write data |
| regWe | output | 1 | Register bank write strobe, one clock wide |
| regRdata | input | 16 | Register bank read data for regAddr |

## Verification
The assertions assume that each serial clock half-period spans more system clocks than the synchroniser depth plus one. This ensures every rising and falling edge is seen as its own single-cycle event. They also assume chip select and host data are stable around each serial clock edge. The bench keeps to this by holding every serial clock level and every data bit for eight system clocks. It also waits several clocks after each chip-select transition before moving the serial clock.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  parameter int DATA_W = 16;              // register word width
  parameter int ADDR_W = 15;              // address bits; one more bit is the write flag
  parameter int PFX_W  = 8;               // command byte width
  localparam int ADDR_END = PFX_W + ADDR_W + 1;
  localparam int WR_END   = ADDR_END + DATA_W;
  localparam int TX_W     = 2 * DATA_W;
  localparam int CNT_W    = $clog2(WR_END + 1);

  typedef enum logic [1:0] {
    CMD_NONE   = 2'b00,
    CMD_WRITE  = 2'b01,
    CMD_READ   = 2'b10,
    CMD_STATUS = 2'b11
  } cmd_e;

  typedef struct packed {
    logic clear;
    logic shiftIn;
    logic shiftOut;
    logic loadTx;
    logic loadStatus;
    logic latchRd;
    logic latchWr;
    logic commitWr;
  } strobe_t;
endpackage

// File: rtl/spi_reg_dp.sv
module spi_reg_dp
  import spi_reg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] ID_WORD = 16'hA5C3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              spiSclk,
  input  logic              spiCsN,
  input  logic              spiMosi,
  input  strobe_t           strb,
  output logic              sclkRise,
  output logic              sclkFall,
  output logic              csIdle,
  output logic [1:0]        pfxCode,
  output logic              wrFlagBit,
  output logic              spiMiso,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWdata,
  output logic              regWe,
  input  logic [DATA_W-1:0] regRdata
);
  localparam int N_SYNC = 3;

  logic [N_SYNC-1:0] rawIn, syncOut;
  assign rawIn = {spiMosi, spiCsN, spiSclk};

  genvar g;
  for (g = 0; g < N_SYNC; g++) begin : g_sync
    localparam logic RST_V = (g == 1) ? 1'b1 : 1'b0;
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= {SYNC_STAGES{RST_V}};
      else       chain <= {chain[SYNC_STAGES-2:0], rawIn[g]};
    end
    assign syncOut[g] = chain[SYNC_STAGES-1];
  end

  logic sclkS, mosiS, sclkPrev;
  assign sclkS  = syncOut[0];
  assign csIdle = syncOut[1];
  assign mosiS  = syncOut[2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sclkPrev <= 1'b0;
    else       sclkPrev <= sclkS;
  end
  assign sclkRise = sclkS & ~sclkPrev;
  assign sclkFall = ~sclkS & sclkPrev;

  // receive shifter: the incoming bit completes the word in rxNext
  logic [DATA_W-2:0] rxShift;
  logic [DATA_W-1:0] rxNext;
  assign rxNext    = {rxShift, mosiS};
  assign pfxCode   = rxNext[PFX_W-1 -: 2];
  assign wrFlagBit = rxNext[ADDR_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rxShift <= '0;
    else if (strb.clear)   rxShift <= '0;
    else if (strb.shiftIn) rxShift <= rxNext[DATA_W-2:0];
  end

  // transmit shifter: two zero bytes then the word
  logic [TX_W-1:0] txShift;
  logic            misoReg;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      misoReg <= 1'b0;
    end else if (strb.clear) begin
      txShift <= '0;
      misoReg <= 1'b0;
    end else if (strb.loadTx) begin
      txShift <= {{DATA_W{1'b0}}, regRdata};
    end else if (strb.loadStatus) begin
      txShift <= {{DATA_W{1'b0}}, ID_WORD};
    end else if (strb.shiftOut) begin
      misoReg <= txShift[TX_W-1];
      txShift <= {txShift[TX_W-2:0], 1'b0};
    end
  end
  assign spiMiso = misoReg;

  // register bank side
  logic [ADDR_W-1:0] rdAddr, wrAddr;
  logic [DATA_W-1:0] wdataReg;
  logic              weReg;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdAddr   <= '0;
      wrAddr   <= '0;
      wdataReg <= '0;
      weReg    <= 1'b0;
    end else begin
      weReg <= strb.commitWr;
      if (strb.latchRd)  rdAddr <= rxNext[ADDR_W-1:0];
      if (strb.latchWr)  wrAddr <= rxNext[ADDR_W-1:0];
      if (strb.commitWr) wdataReg <= rxNext;
    end
  end
  assign regAddr  = weReg ? wrAddr : rdAddr;
  assign regWdata = wdataReg;
  assign regWe    = weReg;

  p_we_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    regWe |=> !regWe);
  p_miso_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    csIdle |=> !spiMiso);
  p_tx_lead_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadTx || strb.loadStatus) |=> (txShift[TX_W-1 -: DATA_W] == '0));
endmodule

// File: rtl/spi_reg_ctrl.sv
module spi_reg_ctrl
  import spi_reg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclkRise,
  input  logic       sclkFall,
  input  logic       csIdle,
  input  logic [1:0] pfxCode,
  input  logic       wrFlagBit,
  output strobe_t    strb
);
  logic [CNT_W-1:0] bitCnt;
  cmd_e             cmd;
  logic             wrFlag;
  logic             done;

  logic atPfx, atAddr, atEnd;
  assign atPfx  = (bitCnt == CNT_W'(PFX_W - 1));
  assign atAddr = (bitCnt == CNT_W'(ADDR_END - 1));
  assign atEnd  = (bitCnt == CNT_W'(WR_END - 1));

  always_comb begin
    strb = '0;
    if (csIdle) begin
      strb.clear = 1'b1;
    end else begin
      if (sclkRise && !done) begin
        strb.shiftIn = 1'b1;
        if (atPfx) begin
          strb.loadTx     = (pfxCode == CMD_READ);
          strb.loadStatus = (pfxCode == CMD_STATUS);
        end
        if (cmd == CMD_WRITE && atAddr) begin
          strb.latchWr = wrFlagBit;
          strb.latchRd = !wrFlagBit;
        end
        if (cmd == CMD_WRITE && wrFlag && atEnd) strb.commitWr = 1'b1;
      end
      if (sclkFall && (cmd == CMD_READ || cmd == CMD_STATUS)) strb.shiftOut = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      cmd    <= CMD_NONE;
      wrFlag <= 1'b0;
      done   <= 1'b0;
    end else if (csIdle) begin
      bitCnt <= '0;
      cmd    <= CMD_NONE;
      wrFlag <= 1'b0;
      done   <= 1'b0;
    end else if (sclkRise && !done) begin
      bitCnt <= bitCnt + 1'b1;
      if (atPfx) begin
        cmd <= cmd_e'(pfxCode);
        if (pfxCode == CMD_NONE) done <= 1'b1;
      end
      if (cmd == CMD_WRITE && atAddr) begin
        wrFlag <= wrFlagBit;
        if (!wrFlagBit) done <= 1'b1;
      end
      if (atEnd) done <= 1'b1;
    end
  end

  p_strobes_exclusive_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadTx, strb.loadStatus, strb.latchRd, strb.latchWr, strb.commitWr}));
  p_abort_resets_r6: assert property (@(posedge clk) disable iff (!rstN)
    csIdle |=> (bitCnt == '0 && !done && cmd == CMD_NONE));
  p_done_freezes_r7: assert property (@(posedge clk) disable iff (!rstN)
    (done && !csIdle) |=> $stable(bitCnt));
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_reg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] ID_WORD = 16'hA5C3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              spiSclk,
  input  logic              spiCsN,
  input  logic              spiMosi,
  output logic              spiMiso,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWdata,
  output logic              regWe,
  input  logic [DATA_W-1:0] regRdata
);
  strobe_t    strb;
  logic       sclkRise, sclkFall, csIdle, wrFlagBit;
  logic [1:0] pfxCode;

  spi_reg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclkRise(sclkRise), .sclkFall(sclkFall),
    .csIdle(csIdle), .pfxCode(pfxCode), .wrFlagBit(wrFlagBit), .strb(strb)
  );

  spi_reg_dp #(.SYNC_STAGES(SYNC_STAGES), .ID_WORD(ID_WORD)) u_dp (
    .clk(clk), .rstN(rstN), .spiSclk(spiSclk), .spiCsN(spiCsN), .spiMosi(spiMosi),
    .strb(strb), .sclkRise(sclkRise), .sclkFall(sclkFall), .csIdle(csIdle),
    .pfxCode(pfxCode), .wrFlagBit(wrFlagBit), .spiMiso(spiMiso),
    .regAddr(regAddr), .regWdata(regWdata), .regWe(regWe), .regRdata(regRdata)
  );
endmodule

// File: tb/spi_reg_slave_tb.sv
module spi_reg_slave_tb;
  localparam int H = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sclk = 1'b0, csN = 1'b1, mosi = 1'b0;
  logic        miso;
  logic [14:0] regAddr;
  logic [15:0] regWdata, regRdata;
  logic        regWe;

  always #2.5 clk = ~clk;

  spi_reg_slave u_dut (
    .clk(clk), .rstN(rstN), .spiSclk(sclk), .spiCsN(csN), .spiMosi(mosi),
    .spiMiso(miso), .regAddr(regAddr), .regWdata(regWdata), .regWe(regWe),
    .regRdata(regRdata)
  );

  // bench register bank and write monitor
  logic [15:0] bank [16];
  int          weCount = 0;
  logic [14:0] lastA = '0;
  logic [15:0] lastD = '0;
  assign regRdata = bank[regAddr[3:0]];

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 16; i++) bank[i] <= '0;
    end else if (regWe) begin
      weCount = weCount + 1;
      lastA   = regAddr;
      lastD   = regWdata;
      bank[regAddr[3:0]] <= regWdata;
    end
  end

  int  checks = 0;
  int  errors = 0;
  bit  finished = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic spiFrame(input int nBits, input logic [63:0] tx, output logic [63:0] rx);
    rx = '0;
    @(negedge clk); csN = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = nBits - 1; i >= 0; i--) begin
      mosi = tx[i];
      repeat (H) @(negedge clk);
      rx = {rx[62:0], miso};
      sclk = 1'b1;
      repeat (H) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (H) @(negedge clk);
    csN = 1'b1; mosi = 1'b0;
    repeat (2 * H) @(negedge clk);
  endtask

  function automatic logic [15:0] valOf(input int a);
    return 16'(a * 16'h1357) ^ 16'hC0DE;
  endfunction

  function automatic logic [14:0] addrOf(input int a);
    return 15'((a << 10) | a);
  endfunction

  function automatic logic [63:0] wrFrame(input logic [7:0] pfx, input logic [14:0] ad, input logic [15:0] d);
    return {24'h0, pfx, 1'b1, ad, d};
  endfunction

  task automatic setAddr(input logic [7:0] pfx, input logic [14:0] ad);
    logic [63:0] rx;
    spiFrame(24, {40'h0, pfx, 1'b0, ad}, rx);
  endtask

  task automatic fetch(input logic [7:0] pfx, output logic [31:0] word);
    logic [63:0] rx;
    spiFrame(40, {24'h0, pfx, 32'h0}, rx);
    word = rx[31:0];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] rx;
    logic [31:0] word;
    int          c0;

    repeat (10) @(negedge clk);
    check(regWe == 1'b0, "R9 regWe after reset", 64'(regWe), 0);
    check(regAddr == '0, "R9 regAddr after reset", 64'(regAddr), 0);
    check(miso == 1'b0, "R9 miso after reset", 64'(miso), 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R2/R1: write sweep, low prefix bits varied
    for (int a = 0; a < 16; a++) begin
      c0 = weCount;
      spiFrame(40, wrFrame(8'h40 | 8'(a * 3), addrOf(a), valOf(a)), rx);
      check(weCount == c0 + 1, "R7 one strobe per write", 64'(weCount - c0), 1);
      check(lastA == addrOf(a), "R2 write address", 64'(lastA), 64'(addrOf(a)));
      check(lastD == valOf(a), "R2 write data", 64'(lastD), 64'(valOf(a)));
      check(miso == 1'b0, "R8 miso idle", 64'(miso), 0);
    end

    // R3/R4: address-set then fetch for every word
    for (int a = 0; a < 16; a++) begin
      c0 = weCount;
      setAddr(8'h40 | 8'(63 - a), addrOf(a));
      check(regAddr == addrOf(a), "R3 pending address", 64'(regAddr), 64'(addrOf(a)));
      check(weCount == c0, "R3 no write on address-set", 64'(weCount - c0), 0);
      fetch(8'h80 | 8'(a), word);
      check(word[31:16] == 16'h0, "R4 leading zero bytes", 64'(word[31:16]), 0);
      check(word[15:0] == valOf(a), "R4 fetched word", 64'(word[15:0]), 64'(valOf(a)));
      check(miso == 1'b0, "R8 miso idle after fetch", 64'(miso), 0);
    end

    // R5: status word
    fetch(8'hC0, word);
    check(word == 32'h0000A5C3, "R5 status word", 64'(word), 64'h0000A5C3);
    fetch(8'hFF, word);
    check(word == 32'h0000A5C3, "R5 status word low bits set", 64'(word), 64'h0000A5C3);

    // R1: command 00 does nothing
    c0 = weCount;
    spiFrame(40, wrFrame(8'h3F, addrOf(3), 16'hFFFF), rx);
    check(weCount == c0, "R1 null command no write", 64'(weCount - c0), 0);
    check(rx == 64'h0, "R1 null command miso zero", rx, 0);
    setAddr(8'h40, addrOf(3));
    fetch(8'h80, word);
    check(word[15:0] == valOf(3), "R1 word kept after null command", 64'(word[15:0]), 64'(valOf(3)));

    // R6: abort mid-data, then a clean write
    c0 = weCount;
    spiFrame(30, wrFrame(8'h40, addrOf(5), 16'hBEEF) >> 10, rx);
    check(weCount == c0, "R6 aborted frame no write", 64'(weCount - c0), 0);
    spiFrame(40, wrFrame(8'h40, addrOf(5), 16'h1234), rx);
    check(weCount == c0 + 1, "R6 next frame decoded", 64'(weCount - c0), 1);
    check(lastD == 16'h1234, "R6 next frame data", 64'(lastD), 64'h1234);
    c0 = weCount;
    spiFrame(20, wrFrame(8'h40, addrOf(6), 16'h0) >> 20, rx);
    check(weCount == c0, "R6 abort in address no write", 64'(weCount - c0), 0);
    setAddr(8'h40, addrOf(5));
    fetch(8'h80, word);
    check(word[15:0] == 16'h1234, "R6 word after abort", 64'(word[15:0]), 64'h1234);

    // R7: extra clocks after a write frame
    c0 = weCount;
    spiFrame(48, {wrFrame(8'h40, addrOf(9), 16'h7E81), 8'hFF}, rx);
    check(weCount == c0 + 1, "R7 extra bits ignored", 64'(weCount - c0), 1);
    check(lastD == 16'h7E81, "R7 data with extra bits", 64'(lastD), 64'h7E81);
    check(miso == 1'b0, "R8 miso idle end", 64'(miso), 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule